// File: doc/BRIEF.md
# Accumulator Stored-Program Processor Core

This block is a very small processor. It keeps a program counter, one accumulator and an instruction register, and it runs programs held in one external synchronous word memory that stores both code and data. The core reaches that memory through a 12-bit address bus, a 16-bit read-data bus, a 16-bit write-data bus and a write-enable line. The memory must return read data in the same cycle in which the address is presented.

Each instruction takes exactly two clock cycles. In the fetch cycle the core reads the word at the program counter into the instruction register and advances the counter. In the execute cycle the core places the instruction's 12-bit operand address on the bus. It then loads, combines or stores the accumulator, or it redirects the program counter. A stop instruction raises a halt output. The halt output holds until reset, and while it is high the core issues no writes and its program counter does not move.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator and the halt flag. In the first cycle after reset the core fetches from address 0 with write-enable low, and a store executed before any load writes 0x0000.
- R2: An instruction word holds the opcode in bits [15:12] and the operand address in bits [11:0]. In the fetch cycle the address bus carries the program counter. In the following execute cycle it carries the operand address, and the next fetch uses the counter plus one.
- R3: Opcode 0 replaces the accumulator with the word read at the operand address.
- R4: Opcode 1 asserts write-enable only in its execute cycle, with the operand address on the address bus and the accumulator on the write-data bus. No other opcode asserts write-enable.
- R5: Opcode 2 adds the operand word to the accumulator in 16-bit two's complement and wraps on overflow.
- R6: Opcode 3 subtracts the operand word from the accumulator and wraps on underflow.
- R7: Opcode 4 loads the program counter with the operand address, so the next fetch happens there.
- R8: Opcode 5 jumps to the operand address only when accumulator bit 15 is 0. Otherwise execution falls through.
- R9: Opcode 6 jumps to the operand address only when the accumulator is non-zero.
- R10: Opcode 7 raises the halt output at the end of its execute cycle. The halt output stays high until reset. While halted, write-enable stays low and the address bus holds the stop instruction's address plus one.
- R11: Opcodes 8 to 15 take both cycles and change neither the accumulator nor the control flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address to the shared memory |
| mem_rdata | input | 16 | Word returned by the memory in the same cycle |
| mem_wdata | output | 16 | Accumulator value offered for a store |
| mem_we | output | 1 | Write strobe for the addressed word |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
Two things coincide in a single execute cycle. The accumulator is read, either as an ALU operand or as a jump condition, and it is rewritten at the same clock edge. On the stop instruction, the halt flag is raised at the same edge at which the sequencer would return to fetch. A table of load/operate/store/stop programs drives the read-modify-write case, including values that cross the sign and carry boundaries, and each is judged by the word stored back into memory. A jump chain places each conditional jump right after the load that sets its condition. The halt case is judged by a frozen address bus and a low write strobe in every cycle after the stop.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h3;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h4;
   localparam logic [OPC_W-1:0] OPC_JPOS  = 4'h5;
   localparam logic [OPC_W-1:0] OPC_JNZ   = 4'h6;
   localparam logic [OPC_W-1:0] OPC_STOP  = 4'h7;

   typedef enum logic {
      PH_FETCH = 1'b0,
      PH_EXEC  = 1'b1
   } phase_e;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_SUB  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    acc_wr;
      alu_op_e alu_op;
      logic    mem_wr;
      logic    pc_wr;
      logic    stop;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic              is_sub;
   logic [DATA_W-1:0] arith;

   assign is_sub = (op == ALU_SUB);

   generate
      if (SUB_VIA_ADDER) begin : g_shared_adder
         logic [DATA_W-1:0] b_inv;
         assign b_inv = is_sub ? ~b : b;
         assign arith = a + b_inv + (is_sub ? ONE : '0);
      end else begin : g_split_units
         assign arith = is_sub ? (a - b) : (a + b);
      end
   endgenerate

   assign y = (op == ALU_PASS) ? b : arith;

endmodule

// File: rtl/acc_cpu_dec.sv
module acc_cpu_dec
   import acc_cpu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             acc_neg,
   input  logic             acc_zero,
   output ctl_t             ctl
);

   always_comb begin
      ctl = '0;
      ctl.alu_op = ALU_PASS;
      unique case (opcode)
         OPC_LOAD:  ctl.acc_wr = 1'b1;
         OPC_STORE: ctl.mem_wr = 1'b1;
         OPC_ADD: begin
            ctl.acc_wr = 1'b1;
            ctl.alu_op = ALU_ADD;
         end
         OPC_SUB: begin
            ctl.acc_wr = 1'b1;
            ctl.alu_op = ALU_SUB;
         end
         OPC_JUMP:  ctl.pc_wr = 1'b1;
         OPC_JPOS:  ctl.pc_wr = ~acc_neg;
         OPC_JNZ:   ctl.pc_wr = ~acc_zero;
         OPC_STOP:  ctl.stop  = 1'b1;
         default:   ctl = '0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   stop_req,
   output phase_e phase,
   output logic   halted
);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= PH_FETCH;
         halted <= 1'b0;
      end else if (!halted) begin
         if (phase == PH_FETCH) begin
            phase <= PH_EXEC;
         end else begin
            phase <= PH_FETCH;
            if (stop_req) halted <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 12,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              halted
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (OPC_LSB != ADDR_W) begin : g_bad_format
         $error("instruction word must be opcode plus address bits");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("address or data width too small");
      end
   endgenerate

   phase_e            phase;
   logic              fetch_c;
   logic              exec_c;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] alu_y;
   logic [ADDR_W-1:0] opnd_addr;
   ctl_t              ctl;

   assign fetch_c   = (phase == PH_FETCH) && !halted;
   assign exec_c    = (phase == PH_EXEC) && !halted;
   assign opnd_addr = ir_q[ADDR_W-1:0];

   acc_cpu_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .stop_req (ctl.stop),
      .phase    (phase),
      .halted   (halted)
   );

   acc_cpu_dec u_dec (
      .opcode   (ir_q[DATA_W-1:OPC_LSB]),
      .acc_neg  (acc_q[DATA_W-1]),
      .acc_zero (acc_q == '0),
      .ctl      (ctl)
   );

   acc_cpu_alu #(
      .DATA_W        (DATA_W),
      .SUB_VIA_ADDER (SUB_VIA_ADDER)
   ) u_alu (
      .op (ctl.alu_op),
      .a  (acc_q),
      .b  (mem_rdata),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         acc_q <= '0;
         ir_q  <= '0;
      end else if (fetch_c) begin
         ir_q <= mem_rdata;
         pc_q <= pc_q + PC_STEP;
      end else if (exec_c) begin
         if (ctl.acc_wr) acc_q <= alu_y;
         if (ctl.pc_wr)  pc_q  <= opnd_addr;
      end
   end

   assign mem_addr  = exec_c ? opnd_addr : pc_q;
   assign mem_wdata = acc_q;
   assign mem_we    = exec_c && ctl.mem_wr;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              fetch_c,
   input logic              exec_c,
   input logic              halted,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] acc,
   input logic [DATA_W-1:0] ir
);

   localparam int OPC_LSB = DATA_W - 4;

   p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_c |=> exec_c);

   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_c |=> (pc == $past(pc) + 1'b1));

   p_ir_capture_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_c |=> (ir == $past(mem_rdata)));

   p_add_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (exec_c && ir[DATA_W-1:OPC_LSB] == 4'h2) |=>
         (acc == $past(acc) + $past(mem_rdata)));

   p_we_store_only_r4: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (exec_c && ir[DATA_W-1:OPC_LSB] == 4'h1));

   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   p_halt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(pc) && $stable(mem_addr)));

   p_nop_keeps_acc_r11: assert property (@(posedge clk) disable iff (rst)
      (exec_c && ir[DATA_W-1]) |=> $stable(acc));

endmodule

bind acc_cpu_core acc_cpu_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .fetch_c   (fetch_c),
   .exec_c    (exec_c),
   .halted    (halted),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_rdata (mem_rdata),
   .pc        (pc_q),
   .acc       (acc_q),
   .ir        (ir_q)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic [15:0] mem_rdata;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic        halted;

   logic [15:0] mem [0:255];
   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   acc_cpu_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .halted    (halted)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we === 1'b1) mem[mem_addr[7:0]] <= mem_wdata;

   // op, a, b, expected stored result
   localparam logic [51:0] VEC [7] = '{
      {4'h2, 16'h7FFF, 16'h0001, 16'h8000},
      {4'h2, 16'hFFFF, 16'h0002, 16'h0001},
      {4'h3, 16'h0000, 16'h0001, 16'hFFFF},
      {4'h3, 16'h1234, 16'h0234, 16'h1000},
      {4'h0, 16'hAAAA, 16'h5555, 16'h5555},
      {4'h8, 16'h1111, 16'h2222, 16'h1111},
      {4'hF, 16'hBEEF, 16'h0001, 16'hBEEF}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk) rst = 1'b0;
   endtask

   function automatic string op_req(input logic [3:0] op);
      case (op)
         4'h0:    return "R3 load";
         4'h2:    return "R5 add";
         4'h3:    return "R6 sub";
         default: return "R11 nop";
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // Reset state, fetch/execute timing and store (R1 R2 R4 R10)
      clear_mem();
      mem[0] = 16'h1040;
      mem[1] = 16'h7000;
      mem[8'h40] = 16'hFFFF;
      do_reset();
      chk("R1 first fetch addr", 16'(mem_addr), 16'h0000);
      chk("R1 we low", 16'(mem_we), 16'h0000);
      chk("R1 halt clear", 16'(halted), 16'h0000);
      @(negedge clk);
      chk("R2 exec addr", 16'(mem_addr), 16'h0040);
      chk("R4 store we", 16'(mem_we), 16'h0001);
      chk("R1 acc zero on wdata", mem_wdata, 16'h0000);
      @(negedge clk);
      chk("R2 next fetch addr", 16'(mem_addr), 16'h0001);
      chk("R4 fetch we low", 16'(mem_we), 16'h0000);
      chk("R4 stored word", mem[8'h40], 16'h0000);
      @(negedge clk);
      chk("R10 not yet halted", 16'(halted), 16'h0000);
      @(negedge clk);
      chk("R10 halted", 16'(halted), 16'h0001);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 addr frozen", 16'(mem_addr), 16'h0002);
         chk("R10 we low", 16'(mem_we), 16'h0000);
         chk("R10 halt held", 16'(halted), 16'h0001);
      end

      // Vector table: load a, operate b, store, stop (R3 R5 R6 R11)
      for (int v = 0; v < 7; v++) begin
         clear_mem();
         mem[0] = 16'h0010;
         mem[1] = {VEC[v][51:48], 12'h011};
         mem[2] = 16'h1012;
         mem[3] = 16'h7000;
         mem[8'h10] = VEC[v][47:32];
         mem[8'h11] = VEC[v][31:16];
         mem[8'h12] = 16'hDEAD;
         do_reset();
         repeat (12) @(negedge clk);
         chk(op_req(VEC[v][51:48]), mem[8'h12], VEC[v][15:0]);
         chk("R10 table halt", 16'(halted), 16'h0001);
         chk("R11 R2 table path", 16'(mem_addr), 16'h0004);
      end

      // Jump chain (R7 R8 R9)
      clear_mem();
      mem[8'h00] = 16'h0030;
      mem[8'h01] = 16'h5020;
      mem[8'h02] = 16'h6008;
      mem[8'h03] = 16'h7000;
      mem[8'h08] = 16'h400C;
      mem[8'h09] = 16'h7000;
      mem[8'h0C] = 16'h0031;
      mem[8'h0D] = 16'h6020;
      mem[8'h0E] = 16'h5010;
      mem[8'h0F] = 16'h7000;
      mem[8'h10] = 16'h1032;
      mem[8'h11] = 16'h7000;
      mem[8'h20] = 16'h7000;
      mem[8'h30] = 16'h8000;
      mem[8'h31] = 16'h0000;
      mem[8'h32] = 16'hDEAD;
      do_reset();
      repeat (24) @(negedge clk);
      chk("R7 R8 R9 jump path end", 16'(mem_addr), 16'h0012);
      chk("R8 jump store reached", mem[8'h32], 16'h0000);
      chk("R10 jump halt", 16'(halted), 16'h0001);

      // Reset clears a held halt (R1)
      do_reset();
      chk("R1 reset clears halt", 16'(halted), 16'h0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule